// File: doc/BRIEF.md
# Branch and Mode-Exchange Next-PC Unit

This unit decides where a processor goes after a branch instruction and which instruction-set mode it runs in afterwards. The processor has a wide mode with 32-bit instructions and a compact mode with 16-bit instructions. Each cycle the unit takes the current PC, the current mode, a two-bit branch kind, a signed word offset from the instruction, a register operand and a condition-pass flag. From these it produces the next PC, the next mode, a link-register write enable with the value to write, and a taken flag. All outputs are registered, so they appear one clock after the inputs are sampled.

The branch kind has two bits. Bit 0 is the link bit: 0 means no link and 1 means a link write. Bit 1 is the exchange bit, which means a mode change is possible. A plain or linking branch always jumps to a PC-relative target. An exchange branch without link always takes its target from the register. An exchange branch with link takes its target either from the offset or from the register, as chosen by a select input. When the target comes from a register, bit 0 of that register gives the new mode and is cleared in the PC.

Top module: `brx_next_pc`

## Requirements
- R1: While reset is asserted, and right after it, next PC, link value, mode, link write and taken are all 0.
- R2: Outputs are registered. The values seen after a rising edge come from the inputs sampled at that edge, and a new input set is accepted on every cycle.
- R3: The sequential address is PC+4 when the mode input is 0 (wide) and PC+2 when it is 1 (compact).
- R4: With cond_ok_i at 0, next PC is the sequential address, the mode is unchanged, and link write, link value and taken are all 0.
- R5: Kind 2'b00 (plain branch), when taken, gives next PC = PC + 8 + (sign-extended 24-bit offset shifted left by 2). The mode is unchanged and there is no link write.
- R6: Kind 2'b01 (branch with link), when taken, uses the R5 target and mode rule, and writes the link with the sequential address.
- R7: Kind 2'b10 (register exchange), when taken, gives next PC = operand with bit 0 cleared and next mode = operand bit 0. There is no link write.
- R8: Kind 2'b11 with use_reg_i at 0 (label exchange with link), when taken, uses the R5 target, sets the mode to 0 and writes the link with sequential address + 1.
- R9: Kind 2'b11 with use_reg_i at 1, when taken, uses the R7 target and mode rule and writes the link with sequential address + 1.
- R10: use_reg_i has no effect on kinds 2'b00, 2'b01 and 2'b10.
- R11: taken_o is 1 exactly when the sampled cond_ok_i was 1.
- R12: All address sums wrap modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_i | input | ADDR_W | Address of the branch instruction |
| narrow_i | input | 1 | Current mode: 0 = wide, 1 = compact |
| kind_i | input | 2 | Branch kind: {exchange, link} |
| use_reg_i | input | 1 | Selects the register target for kind 2'b11 |
| offset_i | input | OFF_W | Signed word offset from the instruction |
| opnd_i | input | ADDR_W | Register operand |
| cond_ok_i | input | 1 | Condition passed |
| pc_nxt_o | output | ADDR_W | Next program counter |
| narrow_o | output | 1 | Next mode |
| link_we_o | output | 1 | Link-register write enable |
| link_o | output | ADDR_W | Value to write to the link register |
| taken_o | output | 1 | Branch taken |

## Verification
The register-target exchange with link is the case where a link write and a mode switch happen in the same cycle. The link value must be the sequential address plus one, taken from the old mode's step size, while the new mode comes from operand bit 0. The sweep provokes this by combining kind 2'b11 and use_reg_i at 1 with both starting modes and with operands whose bit 0 is both 0 and 1. Each cycle it compares the full output tuple against a value computed arithmetically, so an update that mixes up the old and new mode shows up as a wrong link value or a wrong mode.

// File: rtl/brx_pkg.sv
package brx_pkg;

    typedef enum logic [1:0] {
        BRK_PLAIN = 2'b00,
        BRK_LINK  = 2'b01,
        BRK_XCHG  = 2'b10,
        BRK_XLINK = 2'b11
    } brk_e;

    function automatic logic kind_links(input brk_e k);
        return k[0];
    endfunction

    function automatic logic kind_swaps(input brk_e k);
        return k[1];
    endfunction

endpackage

// File: rtl/brx_seq_addr.sv
module brx_seq_addr #(
    parameter int ADDR_W      = 32,
    parameter int WIDE_STEP   = 4,
    parameter int NARROW_STEP = 2
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              narrow_i,
    output logic [ADDR_W-1:0] seq_o,
    output logic [ADDR_W-1:0] seq_mark_o
);
    localparam logic [ADDR_W-1:0] STEP_W = ADDR_W'(WIDE_STEP);
    localparam logic [ADDR_W-1:0] STEP_N = ADDR_W'(NARROW_STEP);

    always_comb begin
        seq_o      = pc_i + (narrow_i ? STEP_N : STEP_W);
        seq_mark_o = seq_o + ADDR_W'(1);
    end
endmodule

// File: rtl/brx_label_tgt.sv
module brx_label_tgt #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 24,
    parameter int SHIFT  = 2,
    parameter int BIAS   = 8
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [OFF_W-1:0]  offset_i,
    output logic [ADDR_W-1:0] tgt_o
);
    localparam int EXT_W = ADDR_W - OFF_W - SHIFT;

    logic [ADDR_W-1:0] disp;

    generate
        if (EXT_W > 0) begin : g_ext
            assign disp = {{EXT_W{offset_i[OFF_W-1]}}, offset_i, {SHIFT{1'b0}}};
        end else begin : g_trunc
            logic [OFF_W+SHIFT-1:0] wide;
            assign wide = {offset_i, {SHIFT{1'b0}}};
            assign disp = wide[ADDR_W-1:0];
        end
    endgenerate

    always_comb begin
        tgt_o = pc_i + ADDR_W'(BIAS) + disp;
    end
endmodule

// File: rtl/brx_reg_tgt.sv
module brx_reg_tgt #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] opnd_i,
    output logic [ADDR_W-1:0] tgt_o,
    output logic              mode_o
);
    always_comb begin
        tgt_o  = {opnd_i[ADDR_W-1:1], 1'b0};
        mode_o = opnd_i[0];
    end
endmodule

// File: rtl/brx_next_pc.sv
module brx_next_pc #(
    parameter int ADDR_W      = 32,
    parameter int OFF_W       = 24,
    parameter int OFF_SHIFT   = 2,
    parameter int PC_BIAS     = 8,
    parameter int WIDE_STEP   = 4,
    parameter int NARROW_STEP = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              narrow_i,
    input  logic [1:0]        kind_i,
    input  logic              use_reg_i,
    input  logic [OFF_W-1:0]  offset_i,
    input  logic [ADDR_W-1:0] opnd_i,
    input  logic              cond_ok_i,
    output logic [ADDR_W-1:0] pc_nxt_o,
    output logic              narrow_o,
    output logic              link_we_o,
    output logic [ADDR_W-1:0] link_o,
    output logic              taken_o
);
    import brx_pkg::*;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic              narrow;
        logic              we;
        logic [ADDR_W-1:0] link;
        logic              taken;
    } res_t;

    res_t res_d, res_q;

    logic [ADDR_W-1:0] seq_addr, seq_mark, lab_tgt, reg_tgt;
    logic              reg_mode;
    brk_e              kind;
    logic              from_reg;

    brx_seq_addr #(
        .ADDR_W(ADDR_W), .WIDE_STEP(WIDE_STEP), .NARROW_STEP(NARROW_STEP)
    ) seq_i (
        .pc_i(pc_i), .narrow_i(narrow_i), .seq_o(seq_addr), .seq_mark_o(seq_mark)
    );

    brx_label_tgt #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .SHIFT(OFF_SHIFT), .BIAS(PC_BIAS)
    ) lab_i (
        .pc_i(pc_i), .offset_i(offset_i), .tgt_o(lab_tgt)
    );

    brx_reg_tgt #(.ADDR_W(ADDR_W)) reg_i (
        .opnd_i(opnd_i), .tgt_o(reg_tgt), .mode_o(reg_mode)
    );

    always_comb begin
        kind     = brk_e'(kind_i);
        from_reg = kind_swaps(kind) & (~kind_links(kind) | use_reg_i);

        res_d.pc     = seq_addr;
        res_d.narrow = narrow_i;
        res_d.we     = 1'b0;
        res_d.link   = '0;
        res_d.taken  = 1'b0;

        if (cond_ok_i) begin
            res_d.taken = 1'b1;
            if (from_reg) begin
                res_d.pc     = reg_tgt;
                res_d.narrow = reg_mode;
            end else begin
                res_d.pc     = lab_tgt;
                res_d.narrow = kind_swaps(kind) ? 1'b0 : narrow_i;
            end
            if (kind_links(kind)) begin
                res_d.we   = 1'b1;
                res_d.link = kind_swaps(kind) ? seq_mark : seq_addr;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign pc_nxt_o  = res_q.pc;
    assign narrow_o  = res_q.narrow;
    assign link_we_o = res_q.we;
    assign link_o    = res_q.link;
    assign taken_o   = res_q.taken;
endmodule

// File: rtl/brx_next_pc_chk.sv
module brx_next_pc_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              narrow_i,
    input logic [1:0]        kind_i,
    input logic              use_reg_i,
    input logic [ADDR_W-1:0] opnd_i,
    input logic              cond_ok_i,
    input logic [ADDR_W-1:0] pc_nxt_o,
    input logic              narrow_o,
    input logic              link_we_o,
    input logic              taken_o
);
    logic armed;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) armed <= 1'b0;
        else         armed <= 1'b1;
    end

    assert_link_needs_take_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        link_we_o |-> taken_o);

    assert_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed && !$past(cond_ok_i)) |->
            (!taken_o && !link_we_o && narrow_o == $past(narrow_i)));

    assert_taken_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed && $past(cond_ok_i)) |-> taken_o);

    assert_plain_mode_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed && taken_o && !$past(kind_i[1])) |-> (narrow_o == $past(narrow_i)));

    assert_xchg_align_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed && taken_o && $past(kind_i) == 2'b10) |->
            (!pc_nxt_o[0] && narrow_o == $past(opnd_i[0])));

    assert_xlink_wide_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed && link_we_o && $past(kind_i) == 2'b11 && !$past(use_reg_i)) |->
            !narrow_o);
endmodule

bind brx_next_pc brx_next_pc_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .narrow_i(narrow_i), .kind_i(kind_i),
    .use_reg_i(use_reg_i), .opnd_i(opnd_i), .cond_ok_i(cond_ok_i),
    .pc_nxt_o(pc_nxt_o), .narrow_o(narrow_o), .link_we_o(link_we_o),
    .taken_o(taken_o)
);

// File: tb/brx_next_pc_tb_top.sv
`timescale 1ns/1ps
module brx_next_pc_tb_top;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [31:0] pc_i = '0;
    logic        narrow_i = 1'b0;
    logic [1:0]  kind_i = '0;
    logic        use_reg_i = 1'b0;
    logic [23:0] offset_i = '0;
    logic [31:0] opnd_i = '0;
    logic        cond_ok_i = 1'b0;
    logic [31:0] pc_nxt_o, link_o;
    logic        narrow_o, link_we_o, taken_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [31:0] e_pc, e_link;
    logic        e_nar, e_we, e_tk;
    string       e_tag;
    bit          pend = 1'b0;

    always #10 clk_i = ~clk_i;

    brx_next_pc dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .pc_i(pc_i), .narrow_i(narrow_i),
        .kind_i(kind_i), .use_reg_i(use_reg_i), .offset_i(offset_i),
        .opnd_i(opnd_i), .cond_ok_i(cond_ok_i), .pc_nxt_o(pc_nxt_o),
        .narrow_o(narrow_o), .link_we_o(link_we_o), .link_o(link_o),
        .taken_o(taken_o)
    );

    task automatic compare(input string tag, input logic [31:0] xp,
                           input logic xn, input logic xw,
                           input logic [31:0] xl, input logic xt);
        checks++;
        if (pc_nxt_o !== xp || narrow_o !== xn || link_we_o !== xw ||
            link_o !== xl || taken_o !== xt) begin
            fails++;
            $display("FAIL %s: got pc=%h m=%b we=%b lk=%h tk=%b exp pc=%h m=%b we=%b lk=%h tk=%b",
                     tag, pc_nxt_o, narrow_o, link_we_o, link_o, taken_o,
                     xp, xn, xw, xl, xt);
        end
    endtask

    // Drive one input set at a falling edge; the previous set's results are
    // visible now (one register stage, R2), so check them first.
    task automatic step(input logic [31:0] pc, input logic nar, input logic [1:0] k,
                        input logic ur, input logic [23:0] off,
                        input logic [31:0] op, input logic c);
        logic [31:0] seq, lab;
        @(negedge clk_i);
        if (pend) compare({e_tag, " R2"}, e_pc, e_nar, e_we, e_link, e_tk);
        pc_i = pc; narrow_i = nar; kind_i = k; use_reg_i = ur;
        offset_i = off; opnd_i = op; cond_ok_i = c;
        seq = nar ? pc + 32'd2 : pc + 32'd4;                      // R3
        lab = pc + 32'd8 + {{6{off[23]}}, off, 2'b00};            // R12 wraps
        e_tk = c;                                                 // R11
        if (!c) begin
            e_pc = seq; e_nar = nar; e_we = 0; e_link = 0; e_tag = "R4";
        end else begin
            case (k)
                2'b00: begin e_pc = lab; e_nar = nar; e_we = 0; e_link = 0;
                             e_tag = ur ? "R10" : "R5"; end
                2'b01: begin e_pc = lab; e_nar = nar; e_we = 1; e_link = seq;
                             e_tag = ur ? "R10" : "R6"; end
                2'b10: begin e_pc = {op[31:1], 1'b0}; e_nar = op[0]; e_we = 0;
                             e_link = 0; e_tag = ur ? "R10" : "R7"; end
                default: begin
                    e_we = 1; e_link = seq + 32'd1;
                    if (ur) begin e_pc = {op[31:1], 1'b0}; e_nar = op[0]; e_tag = "R9"; end
                    else    begin e_pc = lab; e_nar = 1'b0; e_tag = "R8"; end
                end
            endcase
        end
        pend = 1'b1;
    endtask

    initial begin
        #1;
        // R1: state held during reset
        compare("R1", 32'd0, 1'b0, 1'b0, 32'd0, 1'b0);
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        compare("R1", 32'd0, 1'b0, 1'b0, 32'd0, 1'b0);

        // R12: wrap of the sequential address and of the label target
        step(32'hFFFF_FFFC, 1'b0, 2'b00, 1'b0, 24'h0, 32'h0, 1'b0);
        step(32'hFFFF_FFFE, 1'b1, 2'b01, 1'b0, 24'h000001, 32'h0, 1'b1);
        step(32'h0000_0000, 1'b0, 2'b00, 1'b0, 24'h800000, 32'h0, 1'b1);

        // Sweep: every kind x mode x condition x select over 16 operand sets
        for (int i = 0; i < 16; i++) begin
            for (int k = 0; k < 4; k++) begin
                for (int m = 0; m < 2; m++) begin
                    for (int c = 0; c < 2; c++) begin
                        for (int u = 0; u < 2; u++) begin
                            logic [31:0] pcv, opv;
                            logic [23:0] ofv;
                            pcv = (32'h9E37_79B9 * i) & 32'hFFFF_FFFE;
                            if (i == 15) pcv = 32'hFFFF_FFF8;
                            opv = (32'hC2B2_AE35 * (i + 1)) ^ 32'(i + k);
                            case (i % 4)
                                0: ofv = 24'h000000;
                                1: ofv = 24'h7FFFFF;
                                2: ofv = 24'h800000;
                                default: ofv = 24'(32'h00A5_1F3 * i);
                            endcase
                            step(pcv, m[0], k[1:0], u[0], ofv, opv, c[0]);
                        end
                    end
                end
            end
        end
        @(negedge clk_i);
        if (pend) compare({e_tag, " R2"}, e_pc, e_nar, e_we, e_link, e_tk);
        pend = 1'b0;

        // R1: a reset in mid-run clears the registered outputs
        rst_ni = 1'b0;
        #1;
        compare("R1", 32'd0, 1'b0, 1'b0, 32'd0, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule